// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic and Logic Unit with Flag Register

This block is the execution datapath of a small 16-bit RISC core. From an operation code and two operands it forms a result in the same cycle, and it works out the next values of the negative, carry and zero condition flags. Each flag and the result has its own write strobe, and each operation sets those strobes by its own rule. The block holds the three flags in a status word. A flag changes on the rising clock edge only when a valid operation asserts that flag's strobe. The core's decoder drives the operation code and the operands. The core's write-back stage takes `result` whenever `wr_result` is high.

Add-with-carry reads its carry input from the stored carry flag, so a chain of additions needs no extra wiring. Each family of operations has its own carry rule:

- Arithmetic operations produce a carry out.
- Subtracting operations produce a borrow, so carry set means unsigned less-than.
- Shifts report the last bit that leaves the operand.
- Bitwise operations leave the stored carry flag alone.
- Compare changes only the flags and never the result.

Operation codes on `op_sel`:

| Code | Operation |
|------|-----------|
| 0 | add |
| 1 | add with carry |
| 2 | and |
| 3 | or |
| 4 | xor |
| 5 | shift left logical |
| 6 | shift right logical |
| 7 | shift right arithmetic |
| 8 | negate |
| 9 | invert |
| 10 | compare |
| 11 to 15 | undefined |

The flag register has two states. It is cleared by reset, then held or updated on each clock edge.

Top module: `alu16_flags`

## Requirements
- R1: Code 0 gives result = A + B. Code 1 gives result = A + B + stored carry. For both, carry is the carry out of bit 15, and the result, N, C and Z strobes are all high.
- R2: For every operation that writes N and Z, the negative flag equals bit 15 of the result and the zero flag is 1 exactly when the 16-bit result is zero.
- R3: Codes 2 (and), 3 (or), 4 (xor) and 9 (invert, ~A) write the result, N and Z. Their carry strobe stays low, so the stored carry keeps its value across the edge.
- R4: For codes 5 (shift left) and 6 (shift right), an amount B from 1 to 16 shifts A by B and fills with zeros. Carry is the last bit shifted out: A[16-B] for the left shift and A[B-1] for the right shift.
- R5: Code 7 shifts A right by B and fills the vacated high bits with A[15]. For B from 1 to 16, carry is A[B-1].
- R6: A shift amount of 0 gives result = A and writes N and Z. The carry strobe stays low, so the stored carry is unchanged.
- R7: A shift amount above 16 gives result 0 with carry 0 for codes 5 and 6. For code 7 it gives sixteen copies of A[15], with carry A[15].
- R8: Code 10 forms B − A and writes only the flags, with the result strobe low. Carry is 1 when B < A as unsigned numbers.
- R9: Code 8 gives result = 0 − A, with carry 1 exactly when A is nonzero, and writes the result, N, C and Z.
- R10: The status word holds N in bit 4, C in bit 3 and Z in bit 2, with every other bit 0. Reset clears it to 0.
- R11: When `op_valid` is low, or `op_sel` is 11 to 15, every write strobe is low and the status word is unchanged after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 16 | Operand A (shifted value, subtrahend, negate/invert source) |
| opnd_b | input | 16 | Operand B (second addend, shift amount, compare minuend) |
| result | output | 16 | Combinational result |
| wr_result | output | 1 | Result write strobe |
| nxt_neg | output | 1 | Next negative flag |
| nxt_carry | output | 1 | Next carry flag |
| nxt_zero | output | 1 | Next zero flag |
| wr_neg | output | 1 | Negative flag write strobe |
| wr_carry | output | 1 | Carry flag write strobe |
| wr_zero | output | 1 | Zero flag write strobe |
| status | output | 16 | Registered status word |

## Verification
The assertions assume that the clock keeps running while reset is held and that `op_sel` and the operands are held steady between edges. They make no assumption about code values, because codes 11 to 15 and an idle `op_valid` are legal inputs. The stimulus changes inputs only on falling edges. It draws codes from the whole 4-bit range with `op_valid` high most of the time. Shift amounts are biased toward the range 0 to 20, with occasional full-width values, and fixed operand patterns cover the 16-bit carry, borrow and sign boundaries.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_LSL = 4'd5,
        OP_LSR = 4'd6,
        OP_ASR = 4'd7,
        OP_NEG = 4'd8,
        OP_NOT = 4'd9,
        OP_CMP = 4'd10
    } alu_op_e;

    typedef enum logic [1:0] {
        AS_ADD = 2'd0,
        AS_ADC = 2'd1,
        AS_SUB = 2'd2
    } addsub_mode_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RIGHT = 2'd1,
        SH_ARITH = 2'd2
    } shift_kind_e;

    // Bit positions inside the status word; decoded by branch logic elsewhere.
    localparam int ST_NEG   = 4;
    localparam int ST_CARRY = 3;
    localparam int ST_ZERO  = 2;

endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  addsub_mode_e mode,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W:0] wide;

    always_comb begin
        unique case (mode)
            AS_ADD:  wide = {1'b0, x} + {1'b0, y};
            AS_ADC:  wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
            // x - y; the extra top bit becomes a borrow flag
            AS_SUB:  wide = {1'b0, x} - {1'b0, y};
            default: wide = '0;
        endcase
        sum  = wide[W-1:0];
        cout = wide[W];
    end

endmodule

// File: rtl/alu16_shifter.sv
module alu16_shifter
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  shift_kind_e  kind,
    input  logic [W-1:0] value,
    input  logic [W-1:0] amount,
    output logic [W-1:0] shifted,
    output logic         last_out,
    output logic         amount_zero
);

    // Amounts past W all behave like W+1: every original bit has left.
    localparam int AW = $clog2(W + 2);
    localparam logic [W-1:0] AMT_LIM = W'(W);
    localparam logic [AW-1:0] SAT_AMT = AW'(W + 1);

    logic [AW-1:0]       sh;
    logic [2*W:0]        left_ext;
    logic [W:0]          right_ext;
    logic signed [W:0]   arith_ext;

    always_comb begin
        sh          = (amount > AMT_LIM) ? SAT_AMT : amount[AW-1:0];
        amount_zero = (amount == '0);
        left_ext    = {{(W+1){1'b0}}, value} << sh;
        right_ext   = {value, 1'b0} >> sh;
        arith_ext   = $signed({value, 1'b0}) >>> sh;
        unique case (kind)
            SH_LEFT: begin
                shifted  = left_ext[W-1:0];
                last_out = left_ext[W];
            end
            SH_RIGHT: begin
                shifted  = right_ext[W:1];
                last_out = right_ext[0];
            end
            SH_ARITH: begin
                shifted  = arith_ext[W:1];
                last_out = arith_ext[0];
            end
            default: begin
                shifted  = value;
                last_out = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu16_status_reg.sv
module alu16_status_reg
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_neg,
    input  logic         we_carry,
    input  logic         we_zero,
    input  logic         d_neg,
    input  logic         d_carry,
    input  logic         d_zero,
    output logic         q_carry,
    output logic [W-1:0] status
);

    logic flag_n, flag_c, flag_z;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_n <= 1'b0;
            flag_c <= 1'b0;
            flag_z <= 1'b0;
        end else begin
            if (we_neg)   flag_n <= d_neg;
            if (we_carry) flag_c <= d_carry;
            if (we_zero)  flag_z <= d_zero;
        end
    end

    always_comb begin
        status           = '0;
        status[ST_NEG]   = flag_n;
        status[ST_CARRY] = flag_c;
        status[ST_ZERO]  = flag_z;
        q_carry          = flag_c;
    end

    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~((W'(1) << ST_NEG) | (W'(1) << ST_CARRY) | (W'(1) << ST_ZERO))) == '0);

    assert_carry_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !we_carry |=> $stable(status[ST_CARRY]));

    assert_carry_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        we_carry |=> (status[ST_CARRY] == $past(d_carry)));

endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [3:0]   op_sel,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] result,
    output logic         wr_result,
    output logic         nxt_neg,
    output logic         nxt_carry,
    output logic         nxt_zero,
    output logic         wr_neg,
    output logic         wr_carry,
    output logic         wr_zero,
    output logic [W-1:0] status
);

    alu_op_e      op;
    addsub_mode_e as_mode;
    shift_kind_e  sh_kind;
    logic [W-1:0] as_x, as_y, as_sum;
    logic         as_cout;
    logic [W-1:0] sh_res;
    logic         sh_cout, sh_zero;
    logic         cur_carry;
    logic [W-1:0] res_d;
    logic         c_d, wres_d, wn_d, wc_d, wz_d;

    assign op = alu_op_e'(op_sel);

    // Operand steering for the shared adder and shifter.
    always_comb begin
        as_mode = AS_ADD;
        as_x    = opnd_a;
        as_y    = opnd_b;
        sh_kind = SH_LEFT;
        unique case (op)
            OP_ADC: as_mode = AS_ADC;
            OP_NEG: begin
                as_mode = AS_SUB;
                as_x    = '0;
                as_y    = opnd_a;
            end
            OP_CMP: begin
                as_mode = AS_SUB;
                as_x    = opnd_b;
                as_y    = opnd_a;
            end
            OP_LSR:  sh_kind = SH_RIGHT;
            OP_ASR:  sh_kind = SH_ARITH;
            default: ;
        endcase
    end

    alu16_addsub #(.W(W)) u_addsub (
        .mode (as_mode),
        .x    (as_x),
        .y    (as_y),
        .cin  (cur_carry),
        .sum  (as_sum),
        .cout (as_cout)
    );

    alu16_shifter #(.W(W)) u_shifter (
        .kind        (sh_kind),
        .value       (opnd_a),
        .amount      (opnd_b),
        .shifted     (sh_res),
        .last_out    (sh_cout),
        .amount_zero (sh_zero)
    );

    // Result select and per-operation write-strobe rules.
    always_comb begin
        res_d  = '0;
        c_d    = cur_carry;
        wres_d = 1'b0;
        wn_d   = 1'b0;
        wc_d   = 1'b0;
        wz_d   = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC, OP_NEG: begin
                res_d  = as_sum;
                c_d    = as_cout;
                wres_d = 1'b1;
                wn_d   = 1'b1;
                wc_d   = 1'b1;
                wz_d   = 1'b1;
            end
            OP_CMP: begin
                res_d = as_sum;
                c_d   = as_cout;
                wn_d  = 1'b1;
                wc_d  = 1'b1;
                wz_d  = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR, OP_NOT: begin
                unique case (op)
                    OP_AND:  res_d = opnd_a & opnd_b;
                    OP_OR:   res_d = opnd_a | opnd_b;
                    OP_XOR:  res_d = opnd_a ^ opnd_b;
                    default: res_d = ~opnd_a;
                endcase
                wres_d = 1'b1;
                wn_d   = 1'b1;
                wz_d   = 1'b1;
            end
            OP_LSL, OP_LSR, OP_ASR: begin
                res_d  = sh_res;
                c_d    = sh_cout;
                wres_d = 1'b1;
                wn_d   = 1'b1;
                wc_d   = !sh_zero;
                wz_d   = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        result    = res_d;
        nxt_neg   = res_d[W-1];
        nxt_zero  = (res_d == '0);
        nxt_carry = c_d;
        wr_result = op_valid & wres_d;
        wr_neg    = op_valid & wn_d;
        wr_carry  = op_valid & wc_d;
        wr_zero   = op_valid & wz_d;
    end

    alu16_status_reg #(.W(W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_neg   (wr_neg),
        .we_carry (wr_carry),
        .we_zero  (wr_zero),
        .d_neg    (nxt_neg),
        .d_carry  (nxt_carry),
        .d_zero   (nxt_zero),
        .q_carry  (cur_carry),
        .status   (status)
    );

    assert_zero_not_neg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_zero && nxt_zero) |-> !nxt_neg);

    assert_cmp_no_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'd10) |-> (!wr_result && wr_carry));

    assert_logic_keeps_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_sel == 4'd2 || op_sel == 4'd3 || op_sel == 4'd4 || op_sel == 4'd9))
        |-> (!wr_carry && wr_zero && wr_neg));

    assert_zero_shift_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel >= 4'd5 && op_sel <= 4'd7 && opnd_b == '0)
        |-> (!wr_carry && result == opnd_a));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_sel > 4'd10) |=> $stable(status));

endmodule

// File: tb/test_alu16_flags.sv
`timescale 1ns/1ps
module test_alu16_flags;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [15:0] opnd_a = '0, opnd_b = '0;
    logic [15:0] result, status;
    logic        wr_result, nxt_neg, nxt_carry, nxt_zero, wr_neg, wr_carry, wr_zero;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] exp_status = '0;

    always #2 clk = ~clk;

    alu16_flags i_alu16_flags (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .wr_result(wr_result),
        .nxt_neg(nxt_neg), .nxt_carry(nxt_carry), .nxt_zero(nxt_zero),
        .wr_neg(wr_neg), .wr_carry(wr_carry), .wr_zero(wr_zero), .status(status)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1:       return "R1";
            4'd2, 4'd3, 4'd4: return "R3";
            4'd5, 4'd6:       return "R4";
            4'd7:             return "R5";
            4'd8:             return "R9";
            4'd9:             return "R3";
            4'd10:            return "R8";
            default:          return "R11";
        endcase
    endfunction

    // Reference model: {res[15:0], wres, wn, wc, wz, fc}
    function automatic logic [20:0] model(input logic v, input logic [3:0] op,
                                          input logic [15:0] a, input logic [15:0] b,
                                          input logic cin);
        logic [16:0] t;
        logic [15:0] r;
        logic        c, wres, wn, wc, wz;
        int          n;
        r = 16'h0; c = cin; wres = 0; wn = 0; wc = 0; wz = 0;
        case (op)
            4'd0, 4'd1: begin
                t = {1'b0, a} + {1'b0, b} + ((op == 4'd1) ? 17'(cin) : 17'd0);
                r = t[15:0]; c = t[16]; wres = 1; wn = 1; wc = 1; wz = 1;
            end
            4'd2: begin r = a & b; wres = 1; wn = 1; wz = 1; end
            4'd3: begin r = a | b; wres = 1; wn = 1; wz = 1; end
            4'd4: begin r = a ^ b; wres = 1; wn = 1; wz = 1; end
            4'd9: begin r = ~a;    wres = 1; wn = 1; wz = 1; end
            4'd5, 4'd6, 4'd7: begin
                r = a;
                n = (b > 16'd20) ? 20 : int'(b);
                for (int i = 0; i < n; i++) begin
                    if (op == 4'd5) begin c = r[15]; r = {r[14:0], 1'b0}; end
                    else if (op == 4'd6) begin c = r[0]; r = {1'b0, r[15:1]}; end
                    else begin c = r[0]; r = {r[15], r[15:1]}; end
                end
                wres = 1; wn = 1; wz = 1; wc = (b != 16'd0);
            end
            4'd8: begin
                r = 16'h0 - a; c = (a != 16'h0); wres = 1; wn = 1; wc = 1; wz = 1;
            end
            4'd10: begin
                r = b - a; c = (b < a); wn = 1; wc = 1; wz = 1;
            end
            default: ;
        endcase
        if (!v) begin wres = 0; wn = 0; wc = 0; wz = 0; end
        return {r, wres, wn, wc, wz, c};
    endfunction

    task automatic run_op(input logic v, input logic [3:0] op,
                          input logic [15:0] a, input logic [15:0] b);
        logic [20:0] m;
        logic [15:0] r;
        string       tg;
        @(negedge clk);
        op_valid = v; op_sel = op; opnd_a = a; opnd_b = b;
        #1;
        m  = model(v, op, a, b, exp_status[3]);
        r  = m[20:5];
        tg = v ? tag_of(op) : "R11";
        if (v && op >= 4'd5 && op <= 4'd7 && b == 16'd0) tg = "R6";
        if (v && op >= 4'd5 && op <= 4'd7 && b > 16'd16) tg = "R7";
        chk({tg, " strobes"}, {12'h0, wr_result, wr_neg, wr_carry, wr_zero}, {12'h0, m[4:1]});
        if (m[4]) chk({tg, " result"}, result, r);
        if (m[2]) chk({tg, " carry"}, {15'h0, nxt_carry}, {15'h0, m[0]});
        if (m[3]) chk("R2 neg", {15'h0, nxt_neg}, {15'h0, r[15]});
        if (m[1]) chk("R2 zero", {15'h0, nxt_zero}, {15'h0, r == 16'h0});
        if (m[3]) exp_status[4] = r[15];
        if (m[2]) exp_status[3] = m[0];
        if (m[1]) exp_status[2] = (r == 16'h0);
        @(posedge clk);
        #1;
        chk({"R10 status after ", tg}, status, exp_status);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0]  op;
        logic [15:0] a, b;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1 chk("R10 reset status", status, 16'h0);
        rst_n = 1'b1;

        // R1: carry out of bit 15, then add-with-carry consumes it
        run_op(1, 4'd0, 16'hFFFF, 16'h0001);
        run_op(1, 4'd1, 16'h1000, 16'h0200);
        run_op(1, 4'd0, 16'h7FFF, 16'h0001);
        // R3: logic keeps carry (set it first)
        run_op(1, 4'd0, 16'h8000, 16'h8000);
        run_op(1, 4'd2, 16'h00F0, 16'h0F00);
        run_op(1, 4'd9, 16'h0000, 16'h0000);
        // R6: zero shift keeps carry
        run_op(1, 4'd5, 16'h8001, 16'h0000);
        // R4: boundary amounts
        run_op(1, 4'd5, 16'h8001, 16'h0001);
        run_op(1, 4'd5, 16'h0001, 16'h0010);
        run_op(1, 4'd6, 16'h8001, 16'h0001);
        run_op(1, 4'd6, 16'h8000, 16'h0010);
        // R5, R7: arithmetic and oversized shifts
        run_op(1, 4'd7, 16'h8004, 16'h0003);
        run_op(1, 4'd7, 16'h8000, 16'h0011);
        run_op(1, 4'd7, 16'h4000, 16'hFFFF);
        run_op(1, 4'd5, 16'hFFFF, 16'h0011);
        run_op(1, 4'd6, 16'hFFFF, 16'h8000);
        // R8: compare equal / less / greater
        run_op(1, 4'd10, 16'h1234, 16'h1234);
        run_op(1, 4'd10, 16'h0005, 16'h0003);
        run_op(1, 4'd10, 16'h0003, 16'h0005);
        // R9: negate boundaries
        run_op(1, 4'd8, 16'h0000, 16'h0000);
        run_op(1, 4'd8, 16'h8000, 16'h0000);
        run_op(1, 4'd8, 16'h0001, 16'h0000);
        // R11: idle and undefined codes
        run_op(0, 4'd0, 16'hFFFF, 16'hFFFF);
        run_op(1, 4'd11, 16'hFFFF, 16'hFFFF);
        run_op(1, 4'd15, 16'h0000, 16'h0000);

        for (int k = 0; k < 1500; k++) begin
            op = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 3) != 0 && op > 4'd10) op = 4'($urandom_range(0, 10));
            a = 16'($urandom);
            b = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'($urandom_range(0, 20));
            if ($urandom_range(0, 15) == 0) a = ($urandom_range(0, 1) != 0) ? 16'hFFFF : 16'h0000;
            run_op(($urandom_range(0, 9) != 0), op, a, b);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule